// File: doc/BRIEF.md
# Display Interrupt Status Unit

This unit gathers single-cycle event pulses from a display pipeline into sticky status bits. It keeps an enable mask beside them and reports the status gated by that mask. A driver reads the status, writes back the bits it has handled, and then signals that servicing is complete. One interrupt line leaves the block.

The enable mask is never written directly. One address turns enable bits on and another turns them off, so two software contexts can change different bits without a read-modify-write race. Once the interrupt line has fired, it stays high until an end-of-service write arrives. That write forces the line low for at least one cycle, and the line fires again if enabled status is still pending. This gives an edge-sensitive interrupt controller a fresh edge for every service round.

Register map (word addresses on `wr_addr` and `rd_addr`): 0 raw status (read only), 1 masked status (read, write-1-to-clear), 2 enable set, 3 enable clear, 4 end of service (write only). Reads of any other address return zero.

Top module: `irq_status_unit`

## Requirements
- R1: Event input bits 0, 1, 2, 3, 5, 6, 8 and 9 are implemented (frame done, raster done, sync lost, AC-bias count, FIFO underflow, palette loaded, end of frame 0, end of frame 1). A pulse on one of them sets the matching raw status bit at the next clock edge. Bits 4 and 7 and all bits above 9 always read as zero.
- R2: Raw status bits are set whatever the state of the enable mask.
- R3: Reading address 0 returns raw status. Reading address 1 returns raw status AND the enable mask.
- R4: Writing to address 1 clears the raw bits that are written as 1 and are also enabled. Bits written as 0 and disabled bits are kept. Writes to address 0 have no effect.
- R5: If an event pulse and a clear of the same bit arrive in the same cycle, the bit stays set.
- R6: Writing to address 2 enables every implemented bit written as 1. Bits written as 0 are unchanged. A read of address 2 or 3 returns the enable mask.
- R7: Writing to address 3 disables every bit written as 1. Bits written as 0 are unchanged.
- R8: `irq_o` rises one cycle after masked status becomes nonzero. It then stays high until an end-of-service write, even if the status is cleared first.
- R9: A write of any value to address 4 drives `irq_o` low in the next cycle. If masked status is still nonzero, `irq_o` rises again one cycle later. Otherwise it stays low until new enabled status appears.
- R10: After reset, raw status, enable mask and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The first pattern fires all ten event lines with the mask empty. It shows which bits are implemented and that capture does not depend on the mask. A write of all ones to the masked-status address then shows whether disabled bits survive a clear. Set and clear writes are mixed with zero-valued writes, which separates true write-1 semantics from plain stores. The interrupt line is watched across end-of-service writes with status both pending and cleared, to separate the reassert and stay-low cases. A clear and an event on the same bit in the same cycle exposes which of the two takes priority.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
  localparam int EVT_W = 10;
  // implemented sources: 0,1,2,3,5,6,8,9
  localparam logic [EVT_W-1:0] IMPL_MASK = 10'b11_0110_1111;

  typedef enum logic [2:0] {
    A_RAW    = 3'd0,
    A_MASKED = 3'd1,
    A_EN_SET = 3'd2,
    A_EN_CLR = 3'd3,
    A_EOI    = 3'd4
  } irq_addr_e;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_ACTIVE  = 2'd1,
    HS_HOLDOFF = 2'd2
  } hs_state_e;

  // new events win over a clear of the same bit
  function automatic logic [EVT_W-1:0] status_next(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] evt,
    input logic [EVT_W-1:0] clr);
    return ((cur & ~clr) | evt) & IMPL_MASK;
  endfunction

  function automatic logic [EVT_W-1:0] enable_next(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] set,
    input logic [EVT_W-1:0] clr);
    return ((cur | set) & ~clr) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/irqsu_raw_status.sv
module irqsu_raw_status
  import irqsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] raw_o
);
  logic [EVT_W-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= status_next(raw_q, evt_i, clr_i);
  end

  assign raw_o = raw_q;

  p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o & ~IMPL_MASK) == '0);

  p_evt_captured_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & IMPL_MASK) != '0) |=>
      ((raw_o & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK)));

  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((raw_o & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqsu_enable.sv
module irqsu_enable
  import irqsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] en_o
);
  logic [EVT_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= enable_next(en_q, set_i, clr_i);
  end

  assign en_o = en_q;

  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & IMPL_MASK) != '0 && clr_i == '0) |=>
      ((en_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));

  p_clr_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((en_o & $past(clr_i)) == '0));

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(en_o));
endmodule

// File: rtl/irqsu_handshake.sv
module irqsu_handshake
  import irqsu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic eoi_i,
  output logic irq_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:    if (eoi_i) state_d = HS_HOLDOFF;
                  else if (pending_i) state_d = HS_ACTIVE;
      HS_ACTIVE:  if (eoi_i) state_d = HS_HOLDOFF;
      HS_HOLDOFF: if (eoi_i) state_d = HS_HOLDOFF;
                  else if (pending_i) state_d = HS_ACTIVE;
                  else state_d = HS_IDLE;
      default:    state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign irq_o = (state_q == HS_ACTIVE);

  p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i |=> !irq_o);

  p_hold_until_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !eoi_i) |=> irq_o);

  p_fire_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pending_i));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - EVT_W;

  logic [EVT_W-1:0] raw, en, masked, wr_bits;
  logic [EVT_W-1:0] stat_clr, en_set, en_clr;
  logic             wr_masked, wr_set, wr_clr, wr_eoi, pending;

  assign wr_bits   = wr_data[EVT_W-1:0];
  assign wr_masked = wr_en && (wr_addr == ADDR_W'(A_MASKED));
  assign wr_set    = wr_en && (wr_addr == ADDR_W'(A_EN_SET));
  assign wr_clr    = wr_en && (wr_addr == ADDR_W'(A_EN_CLR));
  assign wr_eoi    = wr_en && (wr_addr == ADDR_W'(A_EOI));

  // only bits visible in the masked view can be cleared there
  assign stat_clr = wr_masked ? (wr_bits & en) : '0;
  assign en_set   = wr_set ? wr_bits : '0;
  assign en_clr   = wr_clr ? wr_bits : '0;

  irqsu_raw_status u_raw (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(stat_clr), .raw_o(raw)
  );

  irqsu_enable u_en (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .en_o(en)
  );

  assign masked  = raw & en;
  assign pending = |masked;

  irqsu_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .eoi_i(wr_eoi), .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_RAW))         rd_data = {{PAD_W{1'b0}}, raw};
    else if (rd_addr == ADDR_W'(A_MASKED)) rd_data = {{PAD_W{1'b0}}, masked};
    else if (rd_addr == ADDR_W'(A_EN_SET) || rd_addr == ADDR_W'(A_EN_CLR))
      rd_data = {{PAD_W{1'b0}}, en};
  end

  p_raw_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_RAW) && evt_i == '0) |=> $stable(raw));
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    evt_i = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_status_unit #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [9:0] e);
    evt_i = e;
    @(posedge clk); @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(0, v); check("R10 raw", v, 0);
    rd(2, v); check("R10 enable", v, 0);
    check("R10 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_capture;
    logic [DW-1:0] v;
    pulse(10'h3FF);
    rd(0, v); check("R1 implemented bits", v, 32'h36F);
    rd(1, v); check("R2 masked with no enables", v, 0);
    @(negedge clk);
    check("R2 no irq while disabled", {31'b0, irq_o}, 0);
  endtask

  task automatic t_enable;
    logic [DW-1:0] v;
    wr(2, 32'h005);
    rd(2, v); check("R6 set", v, 32'h005);
    wr(2, 32'h000);
    rd(3, v); check("R6 zero write no effect", v, 32'h005);
    wr(2, 32'h390);
    rd(2, v); check("R6 set adds, unimplemented ignored", v, 32'h305);
    wr(3, 32'h001);
    rd(3, v); check("R7 clear", v, 32'h304);
    wr(3, 32'h000);
    rd(2, v); check("R7 zero write no effect", v, 32'h304);
    rd(1, v); check("R3 masked view", v, 32'h304);
    rd(0, v); check("R3 raw view", v, 32'h36F);
    check("R8 irq high with pending", {31'b0, irq_o}, 1);
  endtask

  task automatic t_clear;
    logic [DW-1:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(0, v); check("R4 clear only enabled bits", v, 32'h06B);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R4 raw write ignored", v, 32'h06B);
    check("R8 irq held after status cleared", {31'b0, irq_o}, 1);
  endtask

  task automatic t_eoi;
    wr(4, 32'h0);
    check("R9 eoi drops irq", {31'b0, irq_o}, 0);
    @(negedge clk); @(negedge clk);
    check("R9 stays low with no status", {31'b0, irq_o}, 0);
    pulse(10'h100);
    check("R8 one cycle latency", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R8 irq rises", {31'b0, irq_o}, 1);
    wr(4, 32'h1234);
    check("R9 low after eoi", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R9 reasserts while pending", {31'b0, irq_o}, 1);
  endtask

  task automatic t_collision;
    logic [DW-1:0] v;
    evt_i = 10'h100;
    wr(1, 32'h100);
    evt_i = '0;
    rd(0, v); check("R5 event beats clear", v & 32'h100, 32'h100);
    wr(1, 32'h100);
    rd(0, v); check("R5 later clear works", v & 32'h100, 32'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_capture;
    t_enable;
    t_clear;
    t_eoi;
    t_collision;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule